// File: doc/BRIEF.md
# LAPD Receive Message Status Controller

This block sits behind an HDLC deframer that has already stripped flags and removed stuffed zero bits. The deframer hands over each frame as a stream of bytes, framed by a start strobe and closed by either an end strobe or an abort strobe. The end strobe comes with a flag that says whether the frame check sequence failed. The controller writes the bytes of each frame into a small receive buffer. It reads the command/response bit and a two-bit message-type code from fixed byte positions. From the type code it derives the expected message length. When a frame closes cleanly it raises a frame-received event.

Software uses a byte-wide register port:

| Address | Content |
|---|---|
| `0x00` | Control register |
| `0x01` | Status register |
| `0x02` | Expected message length for the stored type (read-only) |
| `0x03` | Byte count of the last completed frame (read-only) |
| `0x80` + i | Buffer byte i |

Every read returns its data in the cycle after the read strobe. Software reads the type code and the expected length first, then reads as many buffer bytes as the message holds. A read of the control register acknowledges the event.

Top module: `lapd_rx_status`

## Requirements
- R1: After the synchronous active-high reset, control, status and byte count read `0x00`, the expected length reads 76, and `irq` is 0.
- R2: Control bit 2 (receiver enable) and bit 1 (interrupt enable) are writable and read back. A write to bit 0 or to bits 7:3 has no effect, and those bits read 0.
- R3: Byte i of a frame, counted from 0 after the start strobe, is stored at buffer index i and reads back at address `0x80`+i. All reads return data on `reg_rdata` one cycle after `reg_rd`.
- R4: On completion, status bits 5:4 take bits 1:0 of frame byte 2, coded as follows: 00 = test signal, 01 = idle signal, 10 = path id A, 11 = path id B. Status bit 3 (command/response) takes bit 1 of frame byte 0.
- R5: Address `0x02` reads 82 when the stored type is 11, and 76 for every other type.
- R6: A frame closed by the end strobe sets status bit 1 (end of message) and control bit 0 (interrupt status). It also loads the frame's byte count into address `0x03`.
- R7: An end strobe with the FCS-bad flag sets status bit 2, and end of message is still set.
- R8: An abort strobe inside a frame sets status bit 6. It leaves end of message and interrupt status clear, and it leaves the type, command/response bit and byte count unchanged.
- R9: A start strobe clears end of message, abort and FCS error, but not a pending interrupt status. Status bit 0 reads 1 while a frame is open. Status bit 7 always reads 0.
- R10: `irq` is high exactly when interrupt status and interrupt enable are both 1.
- R11: A read of the control register returns the current interrupt status and then clears it. A frame that completes in the same cycle as that read leaves the bit set.
- R12: While receiver enable is 0, strobes and bytes are ignored, and status, byte count and interrupt status keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Start-of-frame strobe from the deframer |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | End-of-frame strobe |
| rx_fcs_bad | input | 1 | Qualifies `rx_eof`: the frame check failed |
| rx_abort | input | 1 | Abort strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register or buffer address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one cycle after `reg_rd` |
| irq | output | 1 | Frame-received interrupt |

## Verification
The bench reads the control register in the same cycle that a frame completes. A design where the clear beats the set would lose that event. An aborted frame carries its own type and command/response byte values. A design that commits the pending capture on abort would show these in status or the byte count. The bench also starts a new frame while an interrupt is still pending and reads status mid-frame. A start strobe that wipes too much would drop the interrupt status, and one that wipes too little would leave end of message or FCS error visible. The disabled-receiver and mask-off cases show whether the enable gates are applied at the right points.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

    typedef enum logic [1:0] {
        MT_TEST   = 2'b00,
        MT_IDLE   = 2'b01,
        MT_PATH_A = 2'b10,
        MT_PATH_B = 2'b11
    } msg_type_e;

    typedef struct packed {
        logic      sof;
        logic      done;
        logic      aborted;
        logic      fcs_bad;
        logic      cr;
        msg_type_e mtype;
        logic [7:0] nbytes;
    } frame_evt_t;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_STAT = 8'h01;
    localparam logic [7:0] A_ELEN = 8'h02;
    localparam logic [7:0] A_RLEN = 8'h03;

    localparam logic [7:0] LEN_SHORT = 8'd76;
    localparam logic [7:0] LEN_LONG  = 8'd82;

    function automatic logic [7:0] expected_len(msg_type_e t);
        return (t == MT_PATH_B) ? LEN_LONG : LEN_SHORT;
    endfunction

endpackage

// File: rtl/lrx_capture.sv
module lrx_capture
    import lrx_pkg::*;
#(
    parameter int BUF_DEPTH = 128,
    parameter int TYPE_IDX  = 2,
    parameter int CR_IDX    = 0,
    localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eof,
    input  logic              rx_fcs_bad,
    input  logic              rx_abort,
    output frame_evt_t        evt,
    output logic              in_frame,
    output logic              wr_en,
    output logic [BUF_AW-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    logic [7:0] cnt_q;
    logic       cr_q;
    msg_type_e  mtype_q;
    logic       frame_q;

    logic close_abort, close_ok, open_new, take_byte;

    always_comb begin
        close_abort = en && frame_q && rx_abort;
        close_ok    = en && frame_q && rx_eof && !rx_abort;
        open_new    = en && rx_sof && !close_abort && !close_ok;
        take_byte   = en && frame_q && rx_valid && !rx_sof && !rx_eof && !rx_abort;
    end

    always_comb begin
        evt.sof     = open_new;
        evt.done    = close_ok;
        evt.aborted = close_abort;
        evt.fcs_bad = rx_fcs_bad;
        evt.cr      = cr_q;
        evt.mtype   = mtype_q;
        evt.nbytes  = cnt_q;
    end

    assign in_frame = frame_q;
    assign wr_en    = take_byte && ({1'b0, cnt_q} < 9'(BUF_DEPTH));
    assign wr_addr  = cnt_q[BUF_AW-1:0];
    assign wr_data  = rx_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b0;
            cnt_q   <= '0;
            cr_q    <= 1'b0;
            mtype_q <= MT_TEST;
        end else if (!en) begin
            frame_q <= 1'b0;
        end else if (close_abort || close_ok) begin
            frame_q <= 1'b0;
        end else if (open_new) begin
            frame_q <= 1'b1;
            cnt_q   <= '0;
            cr_q    <= 1'b0;
            mtype_q <= MT_TEST;
        end else if (take_byte) begin
            if (cnt_q != 8'hFF) cnt_q <= cnt_q + 8'd1;
            if (cnt_q == 8'(CR_IDX))   cr_q    <= rx_data[1];
            if (cnt_q == 8'(TYPE_IDX)) mtype_q <= msg_type_e'(rx_data[1:0]);
        end
    end

    // R6
    frame_closes_chk: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> !in_frame);

    // R8
    abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(evt.done && evt.aborted));

    // R12
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !in_frame);

endmodule

// File: rtl/lrx_msgbuf.sv
module lrx_msgbuf #(
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/lrx_regs.sv
module lrx_regs
    import lrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t evt,
    input  logic       in_frame,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic [7:0] buf_rdata,
    output logic [7:0] reg_rdata,
    output logic       rx_en,
    output logic       irq
);

    logic       en_q, ie_q, int_q;
    logic       eom_q, fcs_q, abort_q, cr_q;
    msg_type_e  mtype_q;
    logic [7:0] rlen_q;
    logic [7:0] rd_q;
    logic       sel_buf_q;
    logic       done_w;

    logic       unused_wbits;
    assign unused_wbits = ^{reg_wdata[7:3], reg_wdata[0]};

    logic rd_ctrl;
    logic [7:0] ctrl_v, stat_v, mux_v;

    assign done_w  = evt.done;
    assign rd_ctrl = reg_rd && (reg_addr == A_CTRL);

    always_comb begin
        ctrl_v = {5'b0, en_q, ie_q, int_q};
        stat_v = {1'b0, abort_q, mtype_q, cr_q, fcs_q, eom_q, in_frame};
        case (reg_addr)
            A_CTRL:  mux_v = ctrl_v;
            A_STAT:  mux_v = stat_v;
            A_ELEN:  mux_v = expected_len(mtype_q);
            A_RLEN:  mux_v = rlen_q;
            default: mux_v = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            ie_q <= 1'b0;
        end else if (reg_wr && reg_addr == A_CTRL) begin
            en_q <= reg_wdata[2];
            ie_q <= reg_wdata[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           int_q <= 1'b0;
        else if (evt.done) int_q <= 1'b1;
        else if (rd_ctrl)  int_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eom_q   <= 1'b0;
            fcs_q   <= 1'b0;
            abort_q <= 1'b0;
            cr_q    <= 1'b0;
            mtype_q <= MT_TEST;
            rlen_q  <= '0;
        end else if (evt.done) begin
            eom_q   <= 1'b1;
            fcs_q   <= evt.fcs_bad;
            cr_q    <= evt.cr;
            mtype_q <= evt.mtype;
            rlen_q  <= evt.nbytes;
        end else if (evt.aborted) begin
            abort_q <= 1'b1;
        end else if (evt.sof) begin
            eom_q   <= 1'b0;
            fcs_q   <= 1'b0;
            abort_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q      <= '0;
            sel_buf_q <= 1'b0;
        end else if (reg_rd) begin
            rd_q      <= mux_v;
            sel_buf_q <= reg_addr[7];
        end
    end

    assign reg_rdata = sel_buf_q ? buf_rdata : rd_q;
    assign rx_en     = en_q;
    assign irq       = int_q && ie_q;

    // R11
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_ctrl && !done_w) |=> !int_q);

    // R6
    done_sets_chk: assert property (@(posedge clk) disable iff (rst)
        done_w |=> (int_q && eom_q));

    // R6
    int_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_q) |-> $past(done_w));

    // R8
    abort_flags_chk: assert property (@(posedge clk) disable iff (rst)
        evt.aborted |=> (abort_q && !eom_q && $stable(rlen_q)));

endmodule

// File: rtl/lapd_rx_status.sv
module lapd_rx_status
    import lrx_pkg::*;
#(
    parameter int BUF_DEPTH = 128,
    parameter int TYPE_IDX  = 2,
    parameter int CR_IDX    = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_sof,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_eof,
    input  logic       rx_fcs_bad,
    input  logic       rx_abort,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);

    localparam int BUF_AW = $clog2(BUF_DEPTH);

    frame_evt_t        evt;
    logic              in_frame, rx_en;
    logic              wr_en;
    logic [BUF_AW-1:0] wr_addr;
    logic [7:0]        wr_data, buf_rdata;

    lrx_capture #(
        .BUF_DEPTH(BUF_DEPTH),
        .TYPE_IDX (TYPE_IDX),
        .CR_IDX   (CR_IDX)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_en),
        .rx_sof    (rx_sof),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_eof    (rx_eof),
        .rx_fcs_bad(rx_fcs_bad),
        .rx_abort  (rx_abort),
        .evt       (evt),
        .in_frame  (in_frame),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    lrx_msgbuf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .re   (reg_rd && reg_addr[7]),
        .raddr(reg_addr[BUF_AW-1:0]),
        .rdata(buf_rdata)
    );

    lrx_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .in_frame (in_frame),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .buf_rdata(buf_rdata),
        .reg_rdata(reg_rdata),
        .rx_en    (rx_en),
        .irq      (irq)
    );

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[1]) |=> !irq);

endmodule

// File: tb/lapd_rx_status_bench.sv
`timescale 1ns/100ps
module lapd_rx_status_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_sof = 0, rx_valid = 0, rx_eof = 0, rx_fcs_bad = 0, rx_abort = 0;
    logic [7:0] rx_data = 0;
    logic       reg_rd = 0, reg_wr = 0;
    logic [7:0] reg_addr = 0, reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] fb [0:127];

    always #2.5 clk = ~clk;

    lapd_rx_status u_lapd_rx_status (
        .clk(clk), .rst(rst),
        .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eof(rx_eof), .rx_fcs_bad(rx_fcs_bad), .rx_abort(rx_abort),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; v = reg_rdata;
    endtask

    task automatic rdchk(string req, logic [7:0] a, logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic fill(int len, logic [7:0] b0, logic [7:0] b2);
        for (int i = 0; i < 128; i++) fb[i] = 8'(i * 5 + 1);
        fb[0] = b0;
        fb[2] = b2;
        if (len < 0) $display("bad len");
    endtask

    task automatic f_start();
        @(negedge clk); rx_sof = 1;
        @(negedge clk); rx_sof = 0;
    endtask

    task automatic f_bytes(int n);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_data = fb[i];
            @(negedge clk);
        end
        rx_valid = 0;
    endtask

    // kind: 0 good end, 1 end with FCS bad, 2 abort
    task automatic f_end(int kind);
        if (kind == 2) rx_abort = 1;
        else begin rx_eof = 1; rx_fcs_bad = (kind == 1); end
        @(negedge clk);
        rx_abort = 0; rx_eof = 0; rx_fcs_bad = 0;
    endtask

    task automatic frame(int n, int kind);
        f_start(); f_bytes(n); f_end(kind);
    endtask

    task automatic t_reset();
        rdchk("R1 ctrl", 8'h00, 8'h00);
        rdchk("R1 stat", 8'h01, 8'h00);
        rdchk("R1 rlen", 8'h03, 8'h00);
        rdchk("R5 elen at reset", 8'h02, 8'd76);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_ctrl_rw();
        wr(8'h00, 8'hFF);
        rdchk("R2 ctrl writable bits", 8'h00, 8'h06);
        wr(8'h00, 8'h00);
        rdchk("R2 ctrl cleared", 8'h00, 8'h00);
    endtask

    task automatic t_disabled();
        fill(30, 8'h02, 8'h03);
        frame(30, 0);
        rdchk("R12 stat untouched", 8'h01, 8'h00);
        rdchk("R12 ctrl untouched", 8'h00, 8'h00);
        rdchk("R12 rlen untouched", 8'h03, 8'h00);
    endtask

    task automatic t_good();
        wr(8'h00, 8'h04);
        fill(76, 8'h02, 8'h01);
        frame(76, 0);
        chk("R10 irq masked", {7'b0, irq}, 8'h00);
        rdchk("R4 R6 stat idle+cr+eom", 8'h01, 8'h1A);
        rdchk("R5 elen idle", 8'h02, 8'd76);
        rdchk("R6 rlen", 8'h03, 8'd76);
        rdchk("R3 buf0", 8'h80, fb[0]);
        rdchk("R3 buf1", 8'h81, fb[1]);
        rdchk("R3 buf2", 8'h82, fb[2]);
        rdchk("R3 buf75", 8'h80 + 8'd75, fb[75]);
        rdchk("R11 first ctrl read", 8'h00, 8'h05);
        rdchk("R11 second ctrl read", 8'h00, 8'h04);
    endtask

    task automatic t_irq();
        wr(8'h00, 8'h06);
        fill(82, 8'h00, 8'h03);
        frame(82, 0);
        chk("R10 irq raised", {7'b0, irq}, 8'h01);
        rdchk("R4 stat path B", 8'h01, 8'h32);
        rdchk("R5 elen path B", 8'h02, 8'd82);
        rdchk("R6 rlen 82", 8'h03, 8'd82);
        rdchk("R3 buf81", 8'h80 + 8'd81, fb[81]);
        rdchk("R11 ctrl read", 8'h00, 8'h07);
        chk("R10 R11 irq dropped", {7'b0, irq}, 8'h00);
        rdchk("R11 ctrl cleared", 8'h00, 8'h06);
    endtask

    task automatic t_fcs();
        fill(20, 8'h00, 8'h02);
        frame(20, 1);
        rdchk("R7 stat fcs+eom", 8'h01, 8'h26);
        rdchk("R6 rlen 20", 8'h03, 8'd20);
        chk("R7 irq", {7'b0, irq}, 8'h01);
        rdchk("R7 ctrl", 8'h00, 8'h07);
    endtask

    task automatic t_abort();
        fill(40, 8'h02, 8'h03);
        f_start();
        f_bytes(5);
        rdchk("R9 mid-frame stat", 8'h01, 8'h21);
        f_end(2);
        rdchk("R8 stat after abort", 8'h01, 8'h60);
        chk("R8 irq", {7'b0, irq}, 8'h00);
        rdchk("R8 ctrl int clear", 8'h00, 8'h06);
        rdchk("R8 rlen kept", 8'h03, 8'd20);
        rdchk("R8 elen kept", 8'h02, 8'd76);
    endtask

    task automatic t_sof_keeps_int();
        fill(10, 8'h00, 8'h00);
        frame(10, 0);
        rdchk("R6 stat", 8'h01, 8'h02);
        f_start();
        rdchk("R9 sof clears eom", 8'h01, 8'h01);
        rdchk("R9 int kept", 8'h00, 8'h07);
        f_bytes(10);
        f_end(0);
        rdchk("R6 int again", 8'h00, 8'h07);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        wr(8'h00, 8'h04);
        fill(10, 8'h00, 8'h01);
        f_start();
        f_bytes(10);
        rx_eof = 1; reg_rd = 1; reg_addr = 8'h00;
        @(negedge clk);
        rx_eof = 0; reg_rd = 0; v = reg_rdata;
        chk("R11 read during completion", v, 8'h04);
        rdchk("R11 set survives", 8'h00, 8'h05);
        rdchk("R11 then clear", 8'h00, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_ctrl_rw();
        t_disabled();
        t_good();
        t_irq();
        t_fcs();
        t_abort();
        t_sof_keeps_int();
        t_collision();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1..) actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule